// File: doc/BRIEF.md
# Always-On Domain Indirect Register Bridge

This block sits on the CPU register bus and gives software a narrow window into registers that live in a slow, always-on domain such as a real-time clock or power controller. Software never addresses the far registers directly. It loads a byte-enable code, a far address and, for a write, a data word into local registers. It then sets a start bit. The block performs exactly one request/acknowledge transfer toward the far domain.

The control register doubles as the busy indicator, so software polls it until it reads zero. A byte-enable code of zero makes the transfer a read, and the fetched word then appears in the data register. Any nonzero code makes it a write, with 0xF1 as the customary value. The low nibble of the code drives the far-side byte lanes.

While a transfer is running, the local registers are frozen. This keeps the far-side request stable until it is acknowledged.

Top module: `aon_indirect_bridge`

## Requirements
- R1: Four word registers sit at byte offsets 0x0 (control/busy), 0x4 (byte-enable code, 8 bits, zero-extended on read), 0x8 (far address) and 0xC (data). Each reads back the value last loaded into it. Any other offset reads zero.
- R2: A CPU write to offset 0x0 with bit 0 set, made while idle, raises farReq in the next cycle. A write there with bit 0 clear starts nothing.
- R3: Offset 0x0 reads 1 in bit 0, with all other bits zero, while a transfer is in progress, and reads 0 when idle.
- R4: A byte-enable code of 0x00 makes the transfer a read, with farWe=0 and farBe=0. The farRdata value present with farAck is stored into the data register.
- R5: A nonzero byte-enable code, for example 0xF1, makes the transfer a write. It drives farWe=1, farBe = code bits [3:0], farAddr = the address register and farWdata = the data register.
- R6: farReq stays high, with farAddr, farWdata, farWe and farBe unchanged, until farAck is sampled high.
- R7: farReq and the busy flag drop in the cycle after farAck is sampled. The busy time therefore equals the far-side response latency.
- R8: While busy, CPU writes to any of the four registers are ignored, including a second start. The register contents and the far-side request are unaffected.
- R9: After reset, every register reads zero and no transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU register write strobe |
| cpuAddr | input | 4 | CPU register byte offset |
| cpuWdata | input | WORD_W | CPU write data |
| cpuRdata | output | WORD_W | CPU read data for cpuAddr (combinational) |
| farReq | output | 1 | Far-domain transfer request |
| farWe | output | 1 | Far-domain write (1) or read (0) |
| farBe | output | WORD_W/8 | Far-domain byte lanes |
| farAddr | output | WORD_W | Far-domain register address |
| farWdata | output | WORD_W | Far-domain write data |
| farRdata | input | WORD_W | Far-domain read data, valid with farAck |
| farAck | input | 1 | Far-domain acknowledge |

## Verification
The checker watches four things on every cycle: the start of a transfer from idle, the match between the busy readback and the request line, the hold and stability of the request until it is acknowledged, and the drop of the request right after the acknowledge. The bench sweeps the far-side latency from 1 to 16 cycles with a behavioural far register model. For each latency it checks that the busy duration equals that latency, and that byte-lane-masked writes followed by reads return the arithmetically merged words. It also exercises the behaviours a property cannot easily show on its own: register freezing during a busy period and suppression of a second start, both confirmed through readback and a count of far requests.

// File: rtl/aon_bridge_pkg.sv
package aon_bridge_pkg;
  localparam int unsigned OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [OFF_W-1:0] OFF_BE   = 4'h4;
  localparam logic [OFF_W-1:0] OFF_ADDR = 4'h8;
  localparam logic [OFF_W-1:0] OFF_DATA = 4'hC;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldBe;
    logic ldAddr;
    logic ldData;
    logic capRd;
    logic busy;
  } dpStrobe_t;
endpackage

// File: rtl/aon_bridge_ctrl.sv
module aon_bridge_ctrl
  import aon_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [OFF_W-1:0] cpuAddr,
  input  logic             cpuStart,
  input  logic             isWrite,
  input  logic             farAck,
  output logic             farReq,
  output dpStrobe_t        strobe
);
  seqState_t state, stateNxt;
  logic idle;
  logic wrOk;
  logic startGo;

  assign idle    = (state == SEQ_IDLE);
  assign wrOk    = cpuWrEn && idle;   // busy: every CPU write is dropped
  assign startGo = wrOk && (cpuAddr == OFF_CTRL) && cpuStart;

  always_comb begin
    stateNxt = state;
    unique case (state)
      SEQ_IDLE: if (startGo) stateNxt = SEQ_WAIT;
      SEQ_WAIT: if (farAck)  stateNxt = SEQ_IDLE;
      default:               stateNxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

  assign farReq = (state == SEQ_WAIT);

  always_comb begin
    strobe        = '0;
    strobe.ldBe   = wrOk && (cpuAddr == OFF_BE);
    strobe.ldAddr = wrOk && (cpuAddr == OFF_ADDR);
    strobe.ldData = wrOk && (cpuAddr == OFF_DATA);
    strobe.capRd  = (state == SEQ_WAIT) && farAck && !isWrite;
    strobe.busy   = !idle;
  end
endmodule

// File: rtl/aon_bridge_dp.sv
module aon_bridge_dp
  import aon_bridge_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [OFF_W-1:0]    cpuAddr,
  input  logic [WORD_W-1:0]   cpuWdata,
  output logic [WORD_W-1:0]   cpuRdata,
  output logic                isWrite,
  output logic [WORD_W/8-1:0] farBe,
  output logic [WORD_W-1:0]   farAddr,
  output logic [WORD_W-1:0]   farWdata,
  input  logic [WORD_W-1:0]   farRdata
);
  localparam int unsigned LANES = WORD_W / 8;

  logic [BE_W-1:0]   beReg;
  logic [WORD_W-1:0] addrReg;
  logic [WORD_W-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beReg   <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.ldBe)   beReg   <= cpuWdata[BE_W-1:0];
      if (strobe.ldAddr) addrReg <= cpuWdata;
      if (strobe.capRd)  dataReg <= farRdata;
      else if (strobe.ldData) dataReg <= cpuWdata;
    end
  end

  // zero code selects a read, any other code a write
  assign isWrite = (beReg != '0);

  generate
    if (BE_W >= LANES) begin : g_laneFromCode
      assign farBe = beReg[LANES-1:0];
    end else begin : g_lanePad
      assign farBe = {{(LANES-BE_W){1'b0}}, beReg};
    end
  endgenerate

  assign farAddr  = addrReg;
  assign farWdata = dataReg;

  always_comb begin
    cpuRdata = '0;
    unique case (cpuAddr)
      OFF_CTRL: cpuRdata[0]        = strobe.busy;
      OFF_BE:   cpuRdata[BE_W-1:0] = beReg;
      OFF_ADDR: cpuRdata           = addrReg;
      OFF_DATA: cpuRdata           = dataReg;
      default:  cpuRdata           = '0;
    endcase
  end
endmodule

// File: rtl/aon_indirect_bridge.sv
module aon_indirect_bridge
  import aon_bridge_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuWrEn,
  input  logic [3:0]          cpuAddr,
  input  logic [WORD_W-1:0]   cpuWdata,
  output logic [WORD_W-1:0]   cpuRdata,
  output logic                farReq,
  output logic                farWe,
  output logic [WORD_W/8-1:0] farBe,
  output logic [WORD_W-1:0]   farAddr,
  output logic [WORD_W-1:0]   farWdata,
  input  logic [WORD_W-1:0]   farRdata,
  input  logic                farAck
);
  dpStrobe_t strobe;
  logic      isWrite;

  aon_bridge_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cpuWrEn  (cpuWrEn),
    .cpuAddr  (cpuAddr),
    .cpuStart (cpuWdata[0]),
    .isWrite  (isWrite),
    .farAck   (farAck),
    .farReq   (farReq),
    .strobe   (strobe)
  );

  aon_bridge_dp #(.WORD_W(WORD_W), .BE_W(BE_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuRdata (cpuRdata),
    .isWrite  (isWrite),
    .farBe    (farBe),
    .farAddr  (farAddr),
    .farWdata (farWdata),
    .farRdata (farRdata)
  );

  assign farWe = isWrite;
endmodule

// File: rtl/aon_bridge_chk.sv
module aon_bridge_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cpuWrEn,
  input logic [3:0]          cpuAddr,
  input logic                cpuStart,
  input logic [WORD_W-1:0]   cpuRdata,
  input logic                farReq,
  input logic                farWe,
  input logic [WORD_W/8-1:0] farBe,
  input logic [WORD_W-1:0]   farAddr,
  input logic [WORD_W-1:0]   farWdata,
  input logic                farAck
);
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!farReq && cpuWrEn && cpuAddr == 4'h0 && cpuStart) |=> farReq);

  assert_busy_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr == 4'h0) |-> (cpuRdata == {{(WORD_W-1){1'b0}}, farReq}));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (farReq && !farAck) |=> farReq);

  assert_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (farReq && !farAck) |=> ($stable(farAddr) && $stable(farWdata)
                             && $stable(farWe) && $stable(farBe)));

  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (farReq && farAck) |=> !farReq);
endmodule

bind aon_indirect_bridge aon_bridge_chk #(.WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cpuWrEn  (cpuWrEn),
  .cpuAddr  (cpuAddr),
  .cpuStart (cpuWdata[0]),
  .cpuRdata (cpuRdata),
  .farReq   (farReq),
  .farWe    (farWe),
  .farBe    (farBe),
  .farAddr  (farAddr),
  .farWdata (farWdata),
  .farAck   (farAck)
);

// File: tb/aon_indirect_bridge_tb_top.sv
module aon_indirect_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuWrEn = 1'b0;
  logic [3:0]   cpuAddr = 4'h0;
  logic [W-1:0] cpuWdata = '0;
  logic [W-1:0] cpuRdata;
  logic         farReq, farWe;
  logic [3:0]   farBe;
  logic [W-1:0] farAddr, farWdata;
  logic [W-1:0] farRdata = '0;
  logic         farAck = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aon_indirect_bridge dut_i (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .farReq(farReq), .farWe(farWe),
    .farBe(farBe), .farAddr(farAddr), .farWdata(farWdata),
    .farRdata(farRdata), .farAck(farAck)
  );

  // behavioural far-domain register file
  int           latency = 1;
  int           waitCnt = 0;
  int           reqCount = 0;
  logic         reqPrev = 1'b0;
  logic [W-1:0] farMem [16];
  logic [W-1:0] expMem [16];
  logic         lastWe;
  logic [3:0]   lastBe;
  logic [W-1:0] lastAddr;

  initial begin
    for (int i = 0; i < 16; i++) begin
      farMem[i] = 32'h1000_0000 + i * 32'h0101_0101;
      expMem[i] = 32'h1000_0000 + i * 32'h0101_0101;
    end
  end

  always @(negedge clk) begin
    reqPrev <= farReq;
    if (farReq && !reqPrev) reqCount <= reqCount + 1;
    if (farAck) begin
      farAck  <= 1'b0;
      waitCnt <= 0;
    end else if (farReq) begin
      if (waitCnt == latency - 1) begin
        farAck   <= 1'b1;
        lastWe   <= farWe;
        lastBe   <= farBe;
        lastAddr <= farAddr;
        if (farWe) begin
          for (int b = 0; b < 4; b++)
            if (farBe[b]) farMem[farAddr[5:2]][8*b +: 8] <= farWdata[8*b +: 8];
        end else begin
          farRdata <= farMem[farAddr[5:2]];
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [W-1:0] val);
    @(negedge clk);
    cpuAddr = off; cpuWdata = val; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] off, output logic [W-1:0] val);
    cpuAddr = off;
    #1;
    val = cpuRdata;
  endtask

  // counts busy polls, one per cycle, starting right after the start write
  task automatic waitIdle(output int n);
    logic [W-1:0] v;
    n = 0;
    forever begin
      rd(4'h0, v);
      if (v == '0) break;
      n++;
      if (n > 100) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                         input logic [3:0] be);
    logic [W-1:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  initial begin
    logic [W-1:0] v;
    logic [7:0]   codes [4] = '{8'hF1, 8'hFF, 8'h03, 8'h0C};
    int n;
    int rc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    for (int o = 0; o < 16; o += 4) begin
      rd(o[3:0], v);
      check(v == '0, "R9 reset register zero", v, '0);
    end
    check(reqCount == 0, "R9 no request after reset", reqCount, 0);

    // R1 map and readback, unmapped offset
    wr(4'h4, 32'hFFFF_FF5A); rd(4'h4, v); check(v == 32'h5A, "R1 code readback", v, 32'h5A);
    wr(4'h8, 32'hDEAD_BEE8); rd(4'h8, v); check(v == 32'hDEAD_BEE8, "R1 addr readback", v, 32'hDEAD_BEE8);
    wr(4'hC, 32'h1234_5678); rd(4'hC, v); check(v == 32'h1234_5678, "R1 data readback", v, 32'h1234_5678);
    rd(4'h2, v); check(v == '0, "R1 unmapped offset", v, '0);

    // R2 start bit clear does nothing
    rc = reqCount;
    wr(4'h0, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    rd(4'h0, v); check(v == '0, "R2 no start when bit0 clear", v, '0);
    check(reqCount == rc, "R2 no request when bit0 clear", reqCount, rc);

    // latency sweep: masked write then read back
    for (int lat = 1; lat <= 16; lat++) begin
      int idx = (lat * 5) % 16;
      logic [W-1:0] a = 32'h4000_0000 | (idx << 2);
      logic [W-1:0] d = {lat[7:0], ~lat[7:0], 8'hC3, lat[7:0] ^ 8'h5A};
      logic [7:0] code = codes[lat % 4];
      latency = lat;
      wr(4'h4, {24'h0, code}); wr(4'h8, a); wr(4'hC, d);
      rc = reqCount;
      wr(4'h0, 32'h1);
      rd(4'h0, v); check(v == 32'h1, "R3 busy reads one", v, 32'h1);
      waitIdle(n);
      check(n == lat, "R7 write busy equals latency", n, lat);
      check(reqCount == rc + 1, "R2 start raises one request", reqCount, rc + 1);
      check(lastWe == 1'b1 && lastBe == code[3:0] && lastAddr == a,
            "R5 write attributes", {lastWe, lastBe, lastAddr[26:0]}, {1'b1, code[3:0], a[26:0]});
      expMem[idx] = merge(expMem[idx], d, code[3:0]);
      rd(4'hC, v); check(v == d, "R5 data kept after write", v, d);

      wr(4'h4, 32'h0);
      wr(4'h0, 32'h1);
      waitIdle(n);
      check(n == lat, "R7 read busy equals latency", n, lat);
      check(lastWe == 1'b0 && lastBe == 4'h0, "R4 read attributes", {lastWe, lastBe}, 0);
      rd(4'hC, v); check(v == expMem[idx], "R4 read data merged word", v, expMem[idx]);
    end

    // R8 writes ignored while busy
    latency = 16;
    wr(4'h4, 32'hF1); wr(4'h8, 32'h0000_0010); wr(4'hC, 32'hCAFE_F00D);
    rc = reqCount;
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h00); wr(4'h8, 32'h0000_0024); wr(4'hC, 32'h0BAD_0BAD); wr(4'h0, 32'h1);
    rd(4'h0, v); check(v == 32'h1, "R8 still busy", v, 32'h1);
    waitIdle(n);
    repeat (4) @(negedge clk);
    check(reqCount == rc + 1, "R8 second start ignored", reqCount, rc + 1);
    check(lastAddr == 32'h10 && lastWe == 1'b1, "R8 request unaffected", lastAddr, 32'h10);
    rd(4'h4, v); check(v == 32'hF1, "R8 code frozen", v, 32'hF1);
    rd(4'h8, v); check(v == 32'h10, "R8 addr frozen", v, 32'h10);
    rd(4'hC, v); check(v == 32'hCAFE_F00D, "R8 data frozen", v, 32'hCAFE_F00D);
    expMem[4] = merge(expMem[4], 32'hCAFE_F00D, 4'h1);
    latency = 3;
    wr(4'h4, 32'h0); wr(4'h0, 32'h1); waitIdle(n);
    rd(4'hC, v); check(v == expMem[4], "R5 0xF1 writes byte 0 only", v, expMem[4]);
    wr(4'h8, 32'h24); wr(4'h0, 32'h1); waitIdle(n);
    rd(4'hC, v); check(v == expMem[9], "R8 ignored address untouched", v, expMem[9]);

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule